// File: doc/BRIEF.md
# Power-Down Handshake Sequencer

This block coordinates the two halves of a system power-down handshake. In the first half, processor threads each return a stop-grant acknowledge. The block counts these pulses. When the count reaches the programmed thread total, it raises exactly one low-power request toward the downstream I/O hub. That request also stands as the forwarded final acknowledge.

In the second half, a start pulse sends a turn-off message to every downstream port and starts a timeout. The timer stops once every port has returned its turn-off acknowledge. If the selected limit passes first, a sticky expiry flag is raised. The sequence is reported complete once all acknowledges are in. Depending on an override bit, completion also waits for each port's L23-ready indication.

Software programs the block through a small write/read control word. That word holds the thread count, the timeout code and the L23 override. It also holds two status flags that are cleared by writing one: timeout expiry and acknowledge overflow. Each start pulse clears the acknowledge counter, the per-port tracking and the timer.

Top module: `pwrdn_seq`

## Requirements
- R1: After reset the control word reads 0x040: thread field (bits 3:0) 0, timeout code (bits 5:4) 00, L23 override (bit 6) 1, expiry flag (bit 8) 0, overflow flag (bit 9) 0. `lp_req_o`, `turnoff_o` and `seq_done_o` are low.
- R2: With thread field N, the (N+1)th stop-grant acknowledge since the last start produces a one-cycle `lp_req_o` pulse in the cycle after that acknowledge. Earlier acknowledges produce none.
- R3: A stop-grant acknowledge after the request has fired sets the overflow flag (bit 9) and never causes a second request. Writing 1 to bit 9 clears the flag.
- R4: A start pulse clears the acknowledge count, so a further N+1 acknowledges are needed for the next request.
- R5: A start pulse produces a one-cycle `turnoff_o` pulse in the following cycle.
- R6: Timeout code 00 selects 1 ms, 01 selects 10 ms, 10 selects 50 ms, and the reserved code 11 also selects 50 ms. One millisecond equals TICKS_PER_MS clock cycles.
- R7: If not every port has acknowledged when the selected limit elapses after start, the expiry flag (bit 8) becomes 1. Writing 1 to bit 8 clears it.
- R8: Once every port has acknowledged, the timer stops and the expiry flag is not set by that sequence.
- R9: With override bit 6 set to 1, `seq_done_o` rises once all port acknowledges are seen. With it set to 0, `seq_done_o` also requires an L23-ready pulse from every port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_we_i | input | 1 | Control word write strobe |
| csr_wdata_i | input | 16 | Control word write data |
| csr_rdata_o | output | 16 | Control word read data |
| start_i | input | 1 | Begin a new power-down sequence |
| sg_ack_i | input | 1 | Stop-grant acknowledge pulse from a thread |
| lp_req_o | output | 1 | One-cycle low-power request downstream |
| turnoff_o | output | 1 | One-cycle turn-off broadcast to ports |
| port_ack_i | input | NUM_PORTS | Per-port turn-off acknowledge pulses |
| port_l23_i | input | NUM_PORTS | Per-port L23-ready pulses |
| seq_done_o | output | 1 | Sequence complete |

## Verification
Several properties are checked on every cycle by the assertions. Each request pulse lasts one cycle and follows an acknowledge. Every start is followed by a turn-off pulse. A write-one clear of the expiry flag takes effect unless an expiry arrives at the same time. Completion never shows while a port acknowledge is still missing. Other behaviours can only be shown by the bench's scenarios, because they depend on long windows or on programmed values. These are the exact expiry time for each timeout code, the thread count at which the request fires, the overflow behaviour, and the L23 override choice.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  localparam int unsigned MAX_MS = 50;
  localparam int unsigned MS_W   = $clog2(MAX_MS + 1);

  // bit positions in the control word
  localparam int unsigned B_CODE_LO = 4;
  localparam int unsigned B_SKIP    = 6;
  localparam int unsigned B_EXP     = 8;
  localparam int unsigned B_OVF     = 9;

  typedef enum logic [1:0] {
    TMO_1MS  = 2'b00,
    TMO_10MS = 2'b01,
    TMO_50MS = 2'b10,
    TMO_RSVD = 2'b11
  } tmo_code_e;

  function automatic logic [MS_W-1:0] tmo_ms(tmo_code_e c);
    case (c)
      TMO_1MS:  tmo_ms = MS_W'(1);
      TMO_10MS: tmo_ms = MS_W'(10);
      default:  tmo_ms = MS_W'(MAX_MS); // reserved folds to longest
    endcase
  endfunction
endpackage

// File: rtl/pwrdn_ack_counter.sv
module pwrdn_ack_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             fire_o,
  output logic             extra_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      done_q  <= 1'b0;
      fire_o  <= 1'b0;
      extra_o <= 1'b0;
    end else begin
      fire_o  <= 1'b0;
      extra_o <= 1'b0;
      if (clear_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (ack_i) begin
        if (done_q) begin
          extra_o <= 1'b1;
        end else if (cnt_q == limit_i) begin
          fire_o <= 1'b1;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwrdn_port_tracker.sv
module pwrdn_port_tracker #(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic [NUM_PORTS-1:0] ack_i,
  input  logic [NUM_PORTS-1:0] l23_i,
  output logic                 all_ack_o,
  output logic                 all_l23_o
);
  logic [NUM_PORTS-1:0] ack_seen_q, l23_seen_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ack_seen_q[p] <= 1'b0;
        l23_seen_q[p] <= 1'b0;
      end else if (clear_i) begin
        ack_seen_q[p] <= 1'b0;
        l23_seen_q[p] <= 1'b0;
      end else begin
        if (ack_i[p]) ack_seen_q[p] <= 1'b1;
        if (l23_i[p]) l23_seen_q[p] <= 1'b1;
      end
    end
  end

  assign all_ack_o = &ack_seen_q;
  assign all_l23_o = &l23_seen_q;
endmodule

// File: rtl/pwrdn_tmo_timer.sv
module pwrdn_tmo_timer
  import pwrdn_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 50
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      stop_i,
  input  tmo_code_e code_i,
  output logic      expire_o,
  output logic      running_o
);
  localparam int unsigned PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q, lim_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q    <= '0;
      ms_q     <= '0;
      lim_q    <= '0;
      run_q    <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (start_i) begin
        pre_q <= '0;
        ms_q  <= '0;
        lim_q <= tmo_ms(code_i); // limit frozen per sequence
        run_q <= 1'b1;
      end else if (run_q) begin
        if (stop_i) begin
          run_q <= 1'b0;
        end else if (ms_q == lim_q) begin
          run_q    <= 1'b0;
          expire_o <= 1'b1;
        end else if (pre_q == PRE_LAST) begin
          pre_q <= '0;
          ms_q  <= ms_q + 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  assign running_o = run_q;
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pwrdn_pkg::*;
#(
  parameter int unsigned NUM_PORTS    = 4,
  parameter int unsigned TICKS_PER_MS = 50,
  parameter int unsigned SG_W         = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 csr_we_i,
  input  logic [15:0]          csr_wdata_i,
  output logic [15:0]          csr_rdata_o,
  input  logic                 start_i,
  input  logic                 sg_ack_i,
  output logic                 lp_req_o,
  output logic                 turnoff_o,
  input  logic [NUM_PORTS-1:0] port_ack_i,
  input  logic [NUM_PORTS-1:0] port_l23_i,
  output logic                 seq_done_o
);
  logic [SG_W-1:0] sg_lim_q;
  tmo_code_e       code_q;
  logic            skip_q, exp_q, ovf_q, started_q;
  logic            extra_ack, tmr_expire, tmr_running, all_ack, all_l23;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sg_lim_q  <= '0;
      code_q    <= TMO_1MS;
      skip_q    <= 1'b1;
      exp_q     <= 1'b0;
      ovf_q     <= 1'b0;
      started_q <= 1'b0;
      turnoff_o <= 1'b0;
    end else begin
      turnoff_o <= start_i;
      if (start_i) started_q <= 1'b1;
      if (csr_we_i) begin
        sg_lim_q <= csr_wdata_i[SG_W-1:0];
        code_q   <= tmo_code_e'(csr_wdata_i[B_CODE_LO +: 2]);
        skip_q   <= csr_wdata_i[B_SKIP];
      end
      // set beats a simultaneous write-one clear
      if (tmr_expire)                         exp_q <= 1'b1;
      else if (csr_we_i && csr_wdata_i[B_EXP]) exp_q <= 1'b0;
      if (extra_ack)                          ovf_q <= 1'b1;
      else if (csr_we_i && csr_wdata_i[B_OVF]) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    csr_rdata_o                   = '0;
    csr_rdata_o[SG_W-1:0]         = sg_lim_q;
    csr_rdata_o[B_CODE_LO +: 2]   = code_q;
    csr_rdata_o[B_SKIP]           = skip_q;
    csr_rdata_o[B_EXP]            = exp_q;
    csr_rdata_o[B_OVF]            = ovf_q;
  end

  pwrdn_ack_counter #(.CNT_W(SG_W)) u_sg_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i),
    .ack_i   (sg_ack_i),
    .limit_i (sg_lim_q),
    .fire_o  (lp_req_o),
    .extra_o (extra_ack)
  );

  pwrdn_port_tracker #(.NUM_PORTS(NUM_PORTS)) u_ports (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_i),
    .ack_i     (port_ack_i),
    .l23_i     (port_l23_i),
    .all_ack_o (all_ack),
    .all_l23_o (all_l23)
  );

  pwrdn_tmo_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stop_i    (all_ack),
    .code_i    (code_q),
    .expire_o  (tmr_expire),
    .running_o (tmr_running)
  );

  assign seq_done_o = started_q && all_ack && (skip_q || all_l23);
endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        sg_ack_i,
  input logic        csr_we_i,
  input logic [15:0] csr_wdata_i,
  input logic [15:0] csr_rdata_o,
  input logic        lp_req_o,
  input logic        turnoff_o,
  input logic        seq_done_o,
  input logic        tmr_expire,
  input logic        all_ack
);
  p_lp_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_req_o |=> !lp_req_o);

  p_lp_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lp_req_o) |-> $past(sg_ack_i));

  p_turnoff_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> turnoff_o);

  p_exp_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_wdata_i[8] && !tmr_expire) |=> !csr_rdata_o[8]);

  p_done_acks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |-> all_ack);
endmodule

bind pwrdn_seq pwrdn_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .sg_ack_i    (sg_ack_i),
  .csr_we_i    (csr_we_i),
  .csr_wdata_i (csr_wdata_i),
  .csr_rdata_o (csr_rdata_o),
  .lp_req_o    (lp_req_o),
  .turnoff_o   (turnoff_o),
  .seq_done_o  (seq_done_o),
  .tmr_expire  (tmr_expire),
  .all_ack     (all_ack)
);

// File: tb/pwrdn_seq_tb_top.sv
module pwrdn_seq_tb_top;
  localparam int NP  = 4;
  localparam int TPM = 50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          csr_we = 1'b0;
  logic [15:0]   csr_wdata = '0;
  logic [15:0]   csr_rdata;
  logic          start = 1'b0, sg_ack = 1'b0;
  logic          lp_req, turnoff, done;
  logic [NP-1:0] p_ack = '0, p_l23 = '0;
  int            n_chk = 0, n_err = 0;
  bit            finished = 1'b0;

  always #10 clk = ~clk;

  pwrdn_seq #(.NUM_PORTS(NP), .TICKS_PER_MS(TPM), .SG_W(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(csr_we), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata), .start_i(start), .sg_ack_i(sg_ack),
    .lp_req_o(lp_req), .turnoff_o(turnoff), .port_ack_i(p_ack),
    .port_l23_i(p_l23), .seq_done_o(done)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic csr_write(logic [15:0] d);
    csr_we = 1'b1; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0; csr_wdata = '0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic sg_pulse();
    sg_ack = 1'b1;
    @(negedge clk);
    sg_ack = 1'b0;
  endtask

  task automatic port_pulse(logic [NP-1:0] a, logic [NP-1:0] l);
    p_ack = a; p_l23 = l;
    @(negedge clk);
    p_ack = '0; p_l23 = '0;
  endtask

  task automatic t_reset();
    check("R1 csr", csr_rdata, 32'h040);
    check("R1 lp_req", lp_req, 0);
    check("R1 turnoff", turnoff, 0);
    check("R1 done", done, 0);
  endtask

  task automatic t_turnoff();
    pulse_start();
    check("R5 turnoff high", turnoff, 1);
    @(negedge clk);
    check("R5 turnoff one cycle", turnoff, 0);
  endtask

  task automatic t_count();
    csr_write(16'h0042); // three threads, skip=1
    pulse_start();
    for (int i = 0; i < 2; i++) begin
      sg_pulse();
      check("R2 no early request", lp_req, 0);
    end
    sg_pulse();
    check("R2 request on third ack", lp_req, 1);
    @(negedge clk);
    check("R2 request one cycle", lp_req, 0);
  endtask

  task automatic t_overflow();
    sg_pulse();
    check("R3 no second request", lp_req, 0);
    @(negedge clk);
    check("R3 overflow set", csr_rdata[9], 1);
    check("R3 still no request", lp_req, 0);
    csr_write(16'h0242);
    check("R3 overflow cleared", csr_rdata[9], 0);
  endtask

  task automatic t_restart();
    pulse_start();
    for (int i = 0; i < 2; i++) begin
      sg_pulse();
      check("R4 count restarted", lp_req, 0);
    end
    sg_pulse();
    check("R4 request after restart", lp_req, 1);
  endtask

  task automatic t_tmo(logic [1:0] code, int ms);
    csr_write({8'h01, 2'b01, code, 4'h2}); // clear expiry, skip=1
    pulse_start();
    repeat (ms*TPM - 4) @(negedge clk);
    check($sformatf("R6 code %0d not yet expired", code), csr_rdata[8], 0);
    repeat (10) @(negedge clk);
    check($sformatf("R7 code %0d expired", code), csr_rdata[8], 1);
    csr_write({8'h01, 2'b01, code, 4'h2});
    check("R7 expiry cleared by write-one", csr_rdata[8], 0);
  endtask

  task automatic t_stop();
    csr_write(16'h0142);
    pulse_start();
    repeat (10) @(negedge clk);
    port_pulse(4'b0101, '0);
    port_pulse(4'b1010, '0);
    repeat (3*TPM) @(negedge clk);
    check("R8 no expiry after all acks", csr_rdata[8], 0);
    check("R9 done with override", done, 1);
  endtask

  task automatic t_l23();
    csr_write(16'h0002); // skip=0
    pulse_start();
    check("R9 done cleared by start", done, 0);
    port_pulse('1, '0);
    @(negedge clk);
    check("R9 waits for L23", done, 0);
    port_pulse('0, 4'b0111);
    check("R9 one port L23 missing", done, 0);
    port_pulse('0, 4'b1000);
    check("R9 done after all L23", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_turnoff();
    t_count();
    t_overflow();
    t_restart();
    t_tmo(2'b00, 1);
    t_tmo(2'b01, 10);
    t_tmo(2'b10, 50);
    t_tmo(2'b11, 50);
    t_stop();
    t_l23();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule